// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block moves an incoming packet, delivered one byte per beat on a valid/ready stream, into host memory. Where the bytes go is described by a ring of descriptors in that same memory. Each descriptor is two 32-bit words, 8 bytes in all. The first word carries flags and a buffer length. The second word carries the byte address of the buffer. The block reads the descriptor at the current-descriptor register and checks that it owns it. It then fills that descriptor's buffer and chains to further descriptors while bytes remain. It writes a status word back to each descriptor it finishes. When the packet is complete, it writes the first descriptor's status and pulses an interrupt.

Host software programs two registers: the ring start and the current descriptor address. The memory port is word addressed. It allows one request at a time, and read data returns exactly one cycle after the request. Bytes are packed little-endian into words and written with byte strobes. The first descriptor's status is held back until the whole chain has been written, so software never sees a partly built packet.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a byte; goes to `ST_DRAIN` if the ring start is zero, otherwise to `ST_CTRL_REQ`.
- `ST_CTRL_REQ`: reads the first descriptor's control word.
- `ST_CTRL_RSP`: goes to `ST_BUF_REQ` if the descriptor is owned, otherwise to `ST_DRAIN`.
- `ST_BUF_REQ`: reads the buffer address word.
- `ST_BUF_RSP`: goes to `ST_FILL`, or to `ST_PEEK_REQ` when the buffer length is zero.
- `ST_FILL`: accepts bytes; goes to `ST_DATA_WR` when a word is complete, the buffer is full or the packet ends.
- `ST_DATA_WR`: writes the word; goes back to `ST_FILL`, to `ST_PEEK_REQ` when the buffer is full, or to `ST_STAT_WR` at packet end.
- `ST_PEEK_REQ` then `ST_PEEK_RSP`: read the ownership of the next descriptor, then go to `ST_STAT_WR`.
- `ST_STAT_WR`: writes the status and advances the current register; goes to `ST_BUF_REQ` to continue the chain, or to `ST_HEAD_WR`.
- `ST_HEAD_WR`: writes the first status and raises the interrupt; goes to `ST_IDLE`, or to `ST_DRAIN` when bytes remain.
- `ST_DRAIN`: discards bytes until the last one, then returns to `ST_IDLE`.

Top module: `rxr_dma_writer`

## Requirements
- R1: When the ring-start register is zero, a packet is consumed from the stream and discarded. There is no memory write, no interrupt, and the current register is unchanged.
- R2: When bit 31 (owned by the block) of the current descriptor's control word is clear, the packet is discarded with no memory write, no interrupt and no register change.
- R3: Each buffer receives min(length in control bits 12:0, bytes remaining). Buffer byte k goes to byte lane k mod 4 (bits 8*lane+7:8*lane) of word (address >> 2) + k/4. Buffer addresses are word aligned. Only the written lanes have their strobe set, and every write has at least one strobe set.
- R4: The next descriptor is the ring-start value if control bit 30 (wrap) is set, otherwise the current address plus 8. The current register advances to it each time a descriptor is finished.
- R5: When a buffer is full and bytes remain, the block reads the next descriptor's bit 31. If that bit is set, the finished descriptor's status becomes bit 27 (more follows) OR the bytes copied. Descriptors other than the first are written back as soon as they are finished.
- R6: If the next descriptor is not owned, the finished status is just the bytes copied and reception stops. The current register then points at the unowned descriptor, and the rest of the packet is discarded.
- R7: The descriptor that receives the last byte gets status = bytes copied into it + 4, with all flag bits zero.
- R8: The first descriptor's status is written after every other write of the packet. The interrupt is high for exactly one cycle, in the same cycle as that write.
- R9: A packet longer than 8192 bytes is cut to its first 8192 bytes. Byte 8192 is treated as the last byte, and the remaining bytes are discarded.
- R10: Register offset 0x04 holds the ring start and offset 0x08 holds the current descriptor address. Both are readable and writable. Any other offset reads zero and ignores writes. Both registers reset to zero.
- R11: Stream ready is low whenever a descriptor read or any memory write is being issued. It is high only while bytes are being accepted or discarded.
- R12: A descriptor whose length is zero takes no bytes. If the next descriptor is owned, its status becomes bit 27 with count zero and the chain moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of packet |
| s_ready | output | 1 | Stream byte accepted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte strobes |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| irq | output | 1 | Packet-done interrupt pulse |

## Verification
The block is tried with these packets:
- A short packet in a single large buffer. This tests the basic final status.
- A packet spread over buffers of 8, 5 and 64 bytes. The 5-byte buffer leaves lanes partly filled, and this separates the strobe and word-address logic from the chaining.
- A chain that wraps to the ring start, and a chain that stops on an unowned successor. A follow-up packet in the second case shows that the discarded remainder was not written.
- A zero-length buffer.
- A packet that exactly fills its buffer. This must not read the next descriptor.
- An 8200-byte packet, which tests truncation.
- Drop cases with a zero ring start and with an unowned first descriptor.

Every case is compared against a behavioural model of the whole memory, the current register and the interrupt count.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int unsigned OWN_BIT  = 31;
    localparam int unsigned WRAP_BIT = 30;
    localparam int unsigned MORE_BIT = 27;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL_REQ,
        ST_CTRL_RSP,
        ST_BUF_REQ,
        ST_BUF_RSP,
        ST_FILL,
        ST_DATA_WR,
        ST_PEEK_REQ,
        ST_PEEK_RSP,
        ST_STAT_WR,
        ST_HEAD_WR,
        ST_DRAIN
    } rxr_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hw_cur_we,
    input  logic [ADDR_W-1:0] hw_cur,
    output logic [ADDR_W-1:0] ring_start,
    output logic [ADDR_W-1:0] cur_desc
);
    localparam logic [3:0] OFS_RING = 4'h4;
    localparam logic [3:0] OFS_CUR  = 4'h8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_start <= '0;
            cur_desc   <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_RING)
                ring_start <= reg_wdata[ADDR_W-1:0];
            // the engine's own advance wins over a software write
            if (hw_cur_we)
                cur_desc <= hw_cur;
            else if (reg_wr && reg_addr == OFS_CUR)
                cur_desc <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_RING: reg_rdata = 32'(ring_start);
            OFS_CUR:  reg_rdata = 32'(cur_desc);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     load,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [7:0]               data,
    output logic [8*LANES-1:0]       word,
    output logic [LANES-1:0]         be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                be[i]  <= 1'b0;
            end else if (clear) begin
                be[i]  <= 1'b0;
            end else if (load && lane == ($clog2(LANES))'(i)) begin
                byte_q <= data;
                be[i]  <= 1'b1;
            end
        end
        assign word[8*i +: 8] = byte_q;
    end
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 13,
    parameter int MAX_PKT = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int TOT_W = $clog2(MAX_PKT + 1);
    localparam logic [TOT_W-1:0] TOT_MAX = TOT_W'(MAX_PKT);

    rxr_state_e state_q, state_d;

    logic [ADDR_W-1:0] ring_start, cur_desc, next_desc;
    logic [LEN_W-1:0]  len_q, peek_len_q, cnt_q;
    logic              wrap_q, peek_wrap_q, own_q, first_q, done_q, trunc_q;
    logic [TOT_W-1:0]  tot_q;
    logic [WA_W-1:0]   buf_wa_q, head_wa_q, wr_wa_q;
    logic [31:0]       stat_q, head_stat_q, pk_word;
    logic [3:0]        pk_be;
    logic              byte_fire, pkt_end_now, word_cut;
    logic              unused_bits;

    assign unused_bits = ^{mem_rdata[29:28], mem_rdata[26:LEN_W], mem_rdata[1:0],
                           cur_desc[1:0]};

    assign next_desc   = wrap_q ? ring_start : cur_desc + ADDR_W'(8);
    assign byte_fire   = (state_q == ST_FILL) && s_valid;
    assign pkt_end_now = s_last || (tot_q + TOT_W'(1) == TOT_MAX);
    assign word_cut    = (cnt_q[1:0] == 2'd3) || pkt_end_now || (cnt_q + LEN_W'(1) == len_q);

    rxr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_cur_we(state_q == ST_STAT_WR), .hw_cur(next_desc),
        .ring_start(ring_start), .cur_desc(cur_desc)
    );

    rxr_byte_packer #(.LANES(4)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_DATA_WR), .load(byte_fire),
        .lane(cnt_q[1:0]), .data(s_data),
        .word(pk_word), .be(pk_be)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (s_valid) state_d = (ring_start == '0) ? ST_DRAIN : ST_CTRL_REQ;
            ST_CTRL_REQ: state_d = ST_CTRL_RSP;
            ST_CTRL_RSP: state_d = mem_rdata[OWN_BIT] ? ST_BUF_REQ : ST_DRAIN;
            ST_BUF_REQ:  state_d = ST_BUF_RSP;
            ST_BUF_RSP:  state_d = (len_q == '0) ? ST_PEEK_REQ : ST_FILL;
            ST_FILL:     if (s_valid && word_cut) state_d = ST_DATA_WR;
            ST_DATA_WR:  state_d = done_q ? ST_STAT_WR :
                                   (cnt_q == len_q) ? ST_PEEK_REQ : ST_FILL;
            ST_PEEK_REQ: state_d = ST_PEEK_RSP;
            ST_PEEK_RSP: state_d = ST_STAT_WR;
            ST_STAT_WR:  state_d = (done_q || !own_q) ? ST_HEAD_WR : ST_BUF_REQ;
            ST_HEAD_WR:  state_d = (done_q && !trunc_q) ? ST_IDLE : ST_DRAIN;
            ST_DRAIN:    if (s_valid && s_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0; peek_len_q <= '0; cnt_q <= '0; tot_q <= '0;
            wrap_q <= 1'b0; peek_wrap_q <= 1'b0; own_q <= 1'b0;
            first_q <= 1'b0; done_q <= 1'b0; trunc_q <= 1'b0;
            buf_wa_q <= '0; head_wa_q <= '0; wr_wa_q <= '0;
            stat_q <= '0; head_stat_q <= '0;
        end else begin
            unique case (state_q)
                ST_CTRL_REQ: begin
                    head_wa_q <= cur_desc[ADDR_W-1:2];
                    first_q   <= 1'b1;
                    tot_q     <= '0;
                    done_q    <= 1'b0;
                    trunc_q   <= 1'b0;
                end
                ST_CTRL_RSP: begin
                    len_q  <= mem_rdata[LEN_W-1:0];
                    wrap_q <= mem_rdata[WRAP_BIT];
                end
                ST_BUF_RSP: begin
                    buf_wa_q <= mem_rdata[ADDR_W-1:2];
                    cnt_q    <= '0;
                end
                ST_FILL: if (byte_fire) begin
                    wr_wa_q <= buf_wa_q + WA_W'(cnt_q >> 2);
                    cnt_q   <= cnt_q + LEN_W'(1);
                    tot_q   <= tot_q + TOT_W'(1);
                    done_q  <= pkt_end_now;
                    trunc_q <= !s_last && pkt_end_now;
                end
                ST_DATA_WR: if (done_q) stat_q <= 32'(cnt_q) + 32'd4;
                ST_PEEK_RSP: begin
                    own_q       <= mem_rdata[OWN_BIT];
                    peek_len_q  <= mem_rdata[LEN_W-1:0];
                    peek_wrap_q <= mem_rdata[WRAP_BIT];
                    stat_q      <= 32'(cnt_q) | (mem_rdata[OWN_BIT] ? (32'd1 << MORE_BIT) : 32'd0);
                end
                ST_STAT_WR: begin
                    if (first_q) head_stat_q <= stat_q;
                    first_q <= 1'b0;
                    if (!done_q && own_q) begin
                        len_q  <= peek_len_q;
                        wrap_q <= peek_wrap_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        s_ready   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc[ADDR_W-1:2];
        mem_wdata = '0;
        mem_be    = 4'h0;
        irq       = 1'b0;
        unique case (state_q)
            ST_CTRL_REQ: mem_req = 1'b1;
            ST_BUF_REQ: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc[ADDR_W-1:2] + WA_W'(1);
            end
            ST_FILL, ST_DRAIN: s_ready = 1'b1;
            ST_DATA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_wa_q;
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_PEEK_REQ: begin
                mem_req  = 1'b1;
                mem_addr = next_desc[ADDR_W-1:2];
            end
            ST_STAT_WR: if (!first_q) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_q;
                mem_be    = 4'hF;
            end
            ST_HEAD_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = head_wa_q;
                mem_wdata = head_stat_q;
                mem_be    = 4'hF;
                irq       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxr_dma_writer_chk.sv
module rxr_dma_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_ready,
    input logic        irq,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    assert_ready_low_on_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !s_ready);

    assert_irq_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_with_head_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mem_req && mem_we && mem_be == 4'hF));

    assert_write_has_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    assert_ring_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h4) |=> (reg_addr != 4'h4 || reg_rdata == $past(reg_wdata)));
endmodule

bind rxr_dma_writer rxr_dma_writer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/rxr_dma_writer_bench.sv
`timescale 1ns/1ps
module rxr_dma_writer_bench;
    localparam int MW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic        poke_en = 1'b0;
    logic [11:0] poke_idx = '0;
    logic [31:0] poke_val = '0;

    logic [31:0] mem [0:MW-1];
    logic [31:0] exp_mem [0:MW-1];
    logic [7:0]  pkt [$];
    int          total = 0, bad = 0, irq_seen = 0, exp_irq = 0;
    logic [31:0] exp_rs = 0, exp_cur = 0;
    logic        irq_prev = 1'b0;

    always #4 clk = ~clk;

    rxr_dma_writer u_rxr_dma_writer (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory responder: one-cycle read latency, byte-strobed writes, bench pokes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MW; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else if (poke_en) begin
            mem[poke_idx] <= poke_val;
        end else if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:0]];
            end
        end
    end

    // interrupt monitor, sampled away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (irq && irq_prev) begin
                total++; bad++;
                $display("FAIL R8 irq wider than one cycle: act=2+ exp=1");
            end
            irq_prev = irq;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int widx(input logic [31:0] a);
        return int'((a >> 2) & 32'hFFF);
    endfunction

    task automatic poke(input logic [31:0] byte_addr, input logic [31:0] val);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 12'(widx(byte_addr)); poke_val = val;
        exp_mem[widx(byte_addr)] = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] a, input bit own, input bit wrap,
                            input int len, input logic [31:0] buf_a);
        poke(a, {own, wrap, 17'd0, 13'(len)});
        poke(a + 4, buf_a);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // behavioural model of one packet over exp_mem
    task automatic model_rx();
        int n, rem, pos, cp, len;
        logic [31:0] c, w0, bufa, nxt, st, hst, head;
        bit first, nown;
        if (exp_rs == 0) return;
        c = exp_cur;
        if (!exp_mem[widx(c)][31]) return;
        n = (pkt.size() > 8192) ? 8192 : pkt.size();
        rem = n; pos = 0; first = 1; head = c; hst = 0;
        forever begin
            w0 = exp_mem[widx(c)];
            bufa = exp_mem[widx(c + 4)] & ~32'd3;
            len = int'(w0[12:0]);
            cp = (len < rem) ? len : rem;
            for (int k = 0; k < cp; k++)
                exp_mem[widx(bufa + k)][8*((bufa + k) % 4) +: 8] = pkt[pos + k];
            pos += cp; rem -= cp;
            nxt = w0[30] ? exp_rs : c + 8;
            if (rem == 0) begin
                st = cp + 4;
                if (first) hst = st; else exp_mem[widx(c)] = st;
                c = nxt;
                break;
            end
            nown = exp_mem[widx(nxt)][31];
            st = cp | (nown ? 32'h0800_0000 : 32'h0);
            if (first) hst = st; else exp_mem[widx(c)] = st;
            c = nxt; first = 0;
            if (!nown) break;
        end
        exp_mem[widx(head)] = hst;
        exp_cur = c;
        exp_irq++;
    endtask

    task automatic send_pkt();
        for (int i = 0; i < pkt.size(); i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pkt[i]; s_last = (i == pkt.size() - 1);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic run_pkt(input int n, input int seed, input string req);
        logic [31:0] rd;
        int mism, first_bad;
        pkt.delete();
        for (int i = 0; i < n; i++) pkt.push_back(8'((seed * 7 + i * 13 + (i >> 8)) & 8'hFF));
        model_rx();
        send_pkt();
        repeat (12) @(negedge clk);
        mism = 0; first_bad = -1;
        for (int i = 0; i < MW; i++)
            if (mem[i] !== exp_mem[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " memory word"}, mem[first_bad], exp_mem[first_bad]);
        reg_read(4'h8, rd);
        check(rd == exp_cur, {req, " current register"}, rd, exp_cur);
        check(irq_seen == exp_irq, {req, " interrupt count"}, irq_seen, exp_irq);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < MW; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R10, R11)
        reg_read(4'h4, rd); check(rd == 0, "R10 ring start reset", rd, 0);
        reg_read(4'h8, rd); check(rd == 0, "R10 current reset", rd, 0);
        check(s_ready == 1'b0, "R11 ready low when idle", 32'(s_ready), 0);

        // R1: zero ring start drops the packet
        reg_write(4'h8, 32'h100); exp_cur = 32'h100;
        set_desc(32'h100, 1, 0, 64, 32'h1000);
        run_pkt(6, 1, "R1 zero ring start");

        // R10: register access
        reg_write(4'h4, 32'h100); exp_rs = 32'h100;
        reg_read(4'h4, rd); check(rd == 32'h100, "R10 ring start readback", rd, 32'h100);
        reg_write(4'hC, 32'hDEAD_BEEF);
        reg_read(4'hC, rd); check(rd == 0, "R10 unmapped offset reads zero", rd, 0);
        reg_read(4'h4, rd); check(rd == 32'h100, "R10 unmapped write ignored", rd, 32'h100);

        // R2: first descriptor not owned
        set_desc(32'h100, 0, 0, 64, 32'h1000);
        run_pkt(6, 2, "R2 unowned first");

        // R7 R3 R8: single descriptor
        set_desc(32'h100, 1, 0, 64, 32'h1000);
        run_pkt(10, 3, "R7 single buffer");

        // R4 R5 R3: chain of 8, 5 and 64 byte buffers
        set_desc(32'h108, 1, 0, 8, 32'h1100);
        set_desc(32'h110, 1, 0, 5, 32'h1200);
        set_desc(32'h118, 1, 0, 64, 32'h1300);
        run_pkt(20, 4, "R5 chained buffers");

        // R4: wrap back to ring start
        set_desc(32'h120, 1, 1, 6, 32'h1380);
        set_desc(32'h100, 1, 0, 32, 32'h1400);
        run_pkt(15, 5, "R4 wrap to ring start");

        // R6: successor not owned, remainder discarded
        set_desc(32'h108, 1, 0, 4, 32'h1500);
        set_desc(32'h110, 0, 0, 16, 32'h1600);
        run_pkt(10, 6, "R6 unowned successor");
        set_desc(32'h110, 1, 0, 16, 32'h1600);
        run_pkt(3, 7, "R6 next packet after discard");

        // R12: zero-length descriptor
        set_desc(32'h118, 1, 0, 0, 32'h1680);
        set_desc(32'h120, 1, 0, 16, 32'h1700);
        run_pkt(5, 8, "R12 zero length buffer");

        // R9: truncation to 8192 bytes
        set_desc(32'h128, 1, 0, 8191, 32'h1800);
        set_desc(32'h130, 1, 0, 100, 32'h3800);
        run_pkt(8200, 9, "R9 truncation");
        set_desc(32'h138, 1, 0, 8, 32'h3900);
        run_pkt(4, 10, "R9 packet after truncation");

        // R7: packet exactly fills its buffer
        set_desc(32'h140, 1, 0, 6, 32'h3A00);
        set_desc(32'h148, 1, 0, 6, 32'h3B00);
        run_pkt(6, 11, "R7 exact fill");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule